// File: doc/BRIEF.md
# MDIO Management Master

This block drives the two-wire station management bus used to reach Ethernet PHYs. Software sees two 32-bit registers on a plain register bus: a command word and a configuration word. The configuration word chooses between the classic register-access frame format and the extended device/register format, and sets the management clock rate. Writing the command word with its busy flag set launches a single frame. The block serializes that frame on the management data line, reads back the PHY's answer for read operations, then drops busy.

A read result is written into the low half of the command word. A read that the PHY does not acknowledge sets a sticky failure flag. That flag stays set until software writes a command of all zeros. An extended-format register access takes two commands: an address command that loads the register number, then a data command to the same PHY and device.

Top module: `mdio_master`

## Requirements
- R1: After reset, both registers read 0, MDC is low and the MDIO output enable is low.
- R2: Command register (address 0) fields: [15:0] data/address, [20:16] register or device address, [25:21] PHY address, [27:26] opcode, [28] fail, [29] busy, [31:30] read as 0. Config register (address 1) fields: [0] clause select (1 = classic, 0 = extended), [11:4] clock divider, [13] free-running clock. Every other config bit reads 0. A software write never sets fail.
- R3: A frame is PRE_LEN ones, a start code, the 2 opcode bits, the 5-bit PHY address, the 5-bit register/device address, a 2-bit turnaround and 16 data bits, all sent MSB first. The start code is 01 in classic mode and 00 in extended mode. On writes the master drives the turnaround as 10.
- R4: In classic mode, opcode 1 is a write and opcode 2 is a read. The opcode value is sent as the frame's opcode bits.
- R5: In extended mode, opcode 0 (address) and opcode 1 (write) send the data field. Opcodes 2 (read with increment) and 3 (read) are reads.
- R6: A command write with bit 29 = 1 while idle starts a frame. Busy reads 1 until the frame ends, then reads 0. The output enable is low whenever busy is 0.
- R7: Command-register writes made while busy is 1 are ignored. This includes an all-zero write.
- R8: On a completed read, the master releases MDIO from the first turnaround bit onward. The 16 bits sampled from the PHY land in command bits [15:0].
- R9: If MDIO is high when the second turnaround bit of a read is sampled, fail is set, the frame ends at once, busy clears and bits [15:0] keep their value.
- R10: Fail stays set through later commands and non-zero writes. An all-zero command write while idle clears the whole command register.
- R11: The MDC period is 2×(divider+1) system clocks. MDIO changes only on the falling edge of MDC and is sampled on the rising edge.
- R12: With free-running clock off, MDC stays low while idle. With it on, MDC toggles while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register select: 0 command, 1 config |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | High while the master drives MDIO |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The bench builds the block with its default PRE_LEN of 32 and ADDR_W of 2. Every captured frame therefore has the full 64-bit length, and each bit position can be compared with the expected frame. Divider values from 0 to 5 keep each frame to a few hundred clocks. This makes room for many random commands in both clause modes, alongside cases where the PHY does not acknowledge, writes made while busy, and free-running versus parked MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W = 8;
    localparam int TAIL_W = 32;

    // writable bits of each register
    localparam logic [31:0] CFG_MASK = 32'h0000_2FF1;
    localparam logic [31:0] CMD_WMASK = 32'h2FFF_FFFF;

    typedef struct packed {
        logic [1:0]  rsvd;
        logic        busy;
        logic        fail;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } cmd_t;

    typedef struct packed {
        logic [17:0]      pad_hi;
        logic             free_run;
        logic             pad_mid;
        logic [DIV_W-1:0] div;
        logic [2:0]       pad_lo;
        logic             c22;
    } cfg_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_ARM,
        ENG_RUN
    } eng_state_e;

    // frame bits following the preamble, MSB sent first
    function automatic logic [TAIL_W-1:0] frame_tail(
        input logic c22, input logic [1:0] op, input logic [4:0] phy,
        input logic [4:0] regad, input logic [15:0] data);
        return {1'b0, c22, op, phy, regad, 2'b10, data};
    endfunction

    function automatic logic op_is_read(input logic c22, input logic [1:0] op);
        return c22 ? (op == 2'd2) : op[1];
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = en && (cnt == div);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        c22,
    input  logic [1:0]  op,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        done,
    output logic        fail_p,
    output logic        rd_valid,
    output logic [15:0] rd_data
);
    localparam int FRAME_LEN = PRE_LEN + TAIL_W;
    localparam int IDX_W = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] PRE_I  = IDX_W'(PRE_LEN);
    localparam logic [IDX_W-1:0] TA1_I  = IDX_W'(PRE_LEN + 14);
    localparam logic [IDX_W-1:0] TA2_I  = IDX_W'(PRE_LEN + 15);
    localparam logic [IDX_W-1:0] DAT_I  = IDX_W'(PRE_LEN + 16);
    localparam logic [IDX_W-1:0] LAST_I = IDX_W'(FRAME_LEN - 1);

    eng_state_e        state;
    logic [IDX_W-1:0]  idx;
    logic [IDX_W-1:0]  nxt_idx;
    logic [IDX_W-1:0]  rel;
    logic [TAIL_W-1:0] tail;
    logic              rd_q;
    logic              nxt_bit;
    logic              nxt_oe;
    logic [15:0]       sh;

    always_comb begin
        nxt_idx = (state == ENG_ARM) ? '0 : idx + IDX_W'(1);
        rel     = LAST_I - nxt_idx;
        nxt_bit = (nxt_idx < PRE_I) ? 1'b1 : tail[rel[4:0]];
        nxt_oe  = !(rd_q && (nxt_idx >= TA1_I));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            idx      <= '0;
            tail     <= '0;
            rd_q     <= 1'b0;
            sh       <= '0;
            mdio_o   <= 1'b1;
            mdio_oe  <= 1'b0;
            done     <= 1'b0;
            fail_p   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            done     <= 1'b0;
            fail_p   <= 1'b0;
            rd_valid <= 1'b0;
            case (state)
                ENG_IDLE: begin
                    if (start) begin
                        tail  <= frame_tail(c22, op, phy, regad, wdata);
                        rd_q  <= op_is_read(c22, op);
                        state <= ENG_ARM;
                    end
                end
                ENG_ARM: begin
                    if (fall) begin
                        idx     <= nxt_idx;
                        mdio_o  <= nxt_bit;
                        mdio_oe <= nxt_oe;
                        state   <= ENG_RUN;
                    end
                end
                default: begin
                    if (rise && rd_q) begin
                        if (idx == TA2_I && mdio_i) begin
                            fail_p  <= 1'b1;
                            done    <= 1'b1;
                            mdio_oe <= 1'b0;
                            state   <= ENG_IDLE;
                        end else if (idx >= DAT_I) begin
                            sh <= {sh[14:0], mdio_i};
                        end
                    end else if (fall) begin
                        if (idx == LAST_I) begin
                            done     <= 1'b1;
                            rd_valid <= rd_q;
                            mdio_oe  <= 1'b0;
                            mdio_o   <= 1'b1;
                            state    <= ENG_IDLE;
                        end else begin
                            idx     <= nxt_idx;
                            mdio_o  <= nxt_bit;
                            mdio_oe <= nxt_oe;
                        end
                    end
                end
            endcase
        end
    end

    assign rd_data = sh;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    cmd_t        cmd_q;
    cmd_t        cmd_wr;
    cfg_t        cfg_q;
    logic        cmd_we;
    logic        cfg_we;
    logic        wr_zero;
    logic        start;
    logic        cmd_busy;
    logic        cmd_fail;
    logic        clk_en;
    logic        rise;
    logic        fall;
    logic        eng_done;
    logic        eng_fail;
    logic        eng_rd_valid;
    logic [15:0] eng_rd_data;

    assign cmd_busy = cmd_q.busy;
    assign cmd_fail = cmd_q.fail;
    assign cmd_we   = reg_we && (reg_addr == ADDR_W'(0));
    assign cfg_we   = reg_we && (reg_addr == ADDR_W'(1));
    assign wr_zero  = (reg_wdata == 32'd0);
    assign start    = cmd_we && !cmd_busy && reg_wdata[29];
    assign clk_en   = cfg_q.free_run || (cmd_busy && !eng_done);

    always_comb begin
        cmd_wr      = cmd_t'(reg_wdata & CMD_WMASK);
        cmd_wr.fail = cmd_q.fail;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            cfg_q <= '0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_t'(reg_wdata & CFG_MASK);
            if (eng_done) begin
                cmd_q.busy <= 1'b0;
                if (eng_fail)
                    cmd_q.fail <= 1'b1;
                else if (eng_rd_valid)
                    cmd_q.data <= eng_rd_data;
            end else if (cmd_we && !cmd_busy) begin
                cmd_q <= wr_zero ? '0 : cmd_wr;
            end
        end
    end

    always_comb begin
        if (reg_addr == ADDR_W'(0))
            reg_rdata = cmd_q;
        else if (reg_addr == ADDR_W'(1))
            reg_rdata = cfg_q;
        else
            reg_rdata = '0;
    end

    mdio_clkgen u_clk (
        .clk  (clk),
        .rst  (rst),
        .en   (clk_en),
        .div  (cfg_q.div),
        .mdc  (mdc),
        .rise (rise),
        .fall (fall)
    );

    mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .c22      (cfg_q.c22),
        .op       (reg_wdata[27:26]),
        .phy      (reg_wdata[25:21]),
        .regad    (reg_wdata[20:16]),
        .wdata    (reg_wdata[15:0]),
        .rise     (rise),
        .fall     (fall),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (eng_done),
        .fail_p   (eng_fail),
        .rd_valid (eng_rd_valid),
        .rd_data  (eng_rd_data)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic       clk,
    input logic       rst,
    input logic       mdc,
    input logic       mdio_o,
    input logic       mdio_oe,
    input logic       busy,
    input logic       free_run,
    input logic       fail,
    input logic       cmd_we,
    input logic       wr_zero,
    input logic [1:0] op,
    input logic [4:0] phy,
    input logic [4:0] regad
);
    // R6: the line is released whenever no command is in flight
    p_release_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    // R12: parked clock when idle and free-running is off
    p_mdc_parked_r12: assert property (@(posedge clk) disable iff (rst)
        (!busy && !free_run) |=> !mdc);

    // R11: driven data holds while MDC is high
    p_data_hold_high_r11: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc) && mdio_oe && $past(mdio_oe)) |-> $stable(mdio_o));

    // R7: command fields are frozen against writes during a transfer
    p_fields_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_we) |=> ($stable(op) && $stable(phy) && $stable(regad)));

    // R10: fail only clears through an all-zero idle write
    p_fail_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (fail && !(cmd_we && wr_zero && !busy)) |=> fail);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (cmd_busy),
    .free_run (cfg_q.free_run),
    .fail     (cmd_fail),
    .cmd_we   (cmd_we),
    .wr_zero  (wr_zero),
    .op       (cmd_q.op),
    .phy      (cmd_q.phy),
    .regad    (cmd_q.regad)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int PRE = 32;
    localparam int FLEN = PRE + 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_master #(.PRE_LEN(PRE), .ADDR_W(2)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model and line monitor
    bit          in_frame = 0;
    int          fidx = 0;
    bit          cap [0:FLEN-1];
    bit          cap_oe [0:FLEN-1];
    logic [15:0] phy_data = '0;
    bit          phy_resp = 1;
    logic        hold_val = 1'b1;
    int          r11_bad = 0;
    int          all_rises = 0;
    realtime     last_rise = 0;
    realtime     period = 0;

    always @(posedge mdio_oe) begin
        fidx = 0;
        in_frame = 1;
    end

    always @(posedge mdc) begin
        all_rises++;
        if (in_frame && fidx < FLEN) begin
            cap[fidx] = mdio_o;
            cap_oe[fidx] = mdio_oe;
            hold_val = mdio_o;
            if (fidx > 0) period = $realtime - last_rise;
            last_rise = $realtime;
            fidx++;
            if (fidx == PRE + 15) phy_drv = phy_resp ? 1'b0 : 1'b1;
            else if (fidx >= PRE + 16 && fidx < FLEN) phy_drv = phy_data[FLEN-1-fidx];
            else phy_drv = 1'b1;
            if (fidx == FLEN) in_frame = 0;
        end
    end

    always @(negedge clk)
        if (in_frame && fidx > 0 && mdc && mdio_oe && (mdio_o !== hold_val)) r11_bad++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b0;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            rd(2'd0, v);
            if (!v[29]) begin ok = 1; break; end
        end
    endtask

    function automatic logic [31:0] cfg_word(input bit c22, input logic [7:0] div, input bit fr);
        logic [31:0] w = '0;
        w[0] = c22; w[11:4] = div; w[13] = fr;
        return w;
    endfunction

    function automatic bit exp_bit(input int k, input bit c22, input logic [1:0] op,
                                   input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        logic [31:0] t;
        if (k < PRE) return 1'b1;
        t = {1'b0, c22, op, phy, ra, 2'b10, d};
        return t[31-(k-PRE)];
    endfunction

    function automatic bit is_rd(input bit c22, input logic [1:0] op);
        if (c22) return op == 2'd2;
        return op >= 2'd2;
    endfunction

    bit mdl_fail = 0;

    task automatic run(input bit c22, input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] d, input logic [7:0] div,
                       input bit resp, input logic [15:0] pdat, input bit meddle);
        logic [31:0] v, expw;
        bit ok, rdop;
        int bad, nb, last_oe;
        string tag;
        wr(2'd1, cfg_word(c22, div, 1'b0));
        phy_data = pdat; phy_resp = resp; in_frame = 0; phy_drv = 1'b1; r11_bad = 0; period = 0;
        wr(2'd0, {2'b00, 1'b1, 1'b0, op, phy, ra, d});
        rd(2'd0, v);
        check(v[29] == 1'b1, "R6 busy set after start", v, 32'h2000_0000);
        if (meddle) begin
            repeat (40) @(negedge clk);
            wr(2'd0, 32'h0);
            wr(2'd0, {2'b00, 1'b0, 1'b0, ~op, ~phy, ~ra, ~d});
        end
        wait_idle(ok);
        check(ok, "R6 busy clears at frame end", {31'd0, ok}, 32'd1);
        rdop = is_rd(c22, op);
        mdl_fail = mdl_fail | (rdop && !resp);
        expw = {2'b00, 1'b0, mdl_fail, op, phy, ra, (rdop && resp) ? pdat : d};
        rd(2'd0, v);
        check(v == expw, rdop ? (resp ? "R8 read data returned" : "R9 fail on no ack")
                              : (meddle ? "R7 busy write ignored" : "R10 cmd after write"), v, expw);
        bad = 0;
        nb = rdop ? PRE + 14 : FLEN;
        last_oe = rdop ? (resp ? FLEN - 1 : PRE + 15) : -1;
        for (int k = 0; k < nb; k++)
            if (cap[k] !== exp_bit(k, c22, op, phy, ra, d) || !cap_oe[k]) bad++;
        for (int k = PRE + 14; k <= last_oe; k++)
            if (cap_oe[k]) bad++;
        tag = c22 ? "R3 R4 frame bits" : "R3 R5 frame bits";
        check(bad == 0, tag, bad, 0);
        if (rdop && !resp)
            check(fidx == PRE + 16, "R9 frame cut after turnaround", fidx, PRE + 16);
        check(period == 5.0 * 2 * (div + 1) && r11_bad == 0, "R11 MDC period and edges",
              int'(period), 10 * (div + 1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cnt;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); check(v == 0, "R1 cmd reset", v, 0);
        rd(2'd1, v); check(v == 0, "R1 cfg reset", v, 0);
        check(mdc == 0 && mdio_oe == 0, "R1 line idle", {mdc, mdio_oe}, 0);

        // R2 field layout
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, v); check(v == 32'h0000_2FF1, "R2 cfg mask", v, 32'h0000_2FF1);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hDFFF_FFFF);
        rd(2'd0, v); check(v == 32'h0FFF_FFFF, "R2 cmd mask", v, 32'h0FFF_FFFF);
        wr(2'd0, 32'h0);

        // R12 free-running versus parked clock
        wr(2'd1, cfg_word(1'b1, 8'd1, 1'b1));
        cnt = all_rises;
        repeat (40) @(negedge clk);
        check(all_rises - cnt >= 8, "R12 free-run toggles idle", all_rises - cnt, 8);
        wr(2'd1, cfg_word(1'b1, 8'd1, 1'b0));
        repeat (2) @(negedge clk);
        cnt = all_rises;
        repeat (40) @(negedge clk);
        check(all_rises == cnt && mdc == 0, "R12 parked when idle", all_rises - cnt, 0);

        // directed frames
        run(1'b1, 2'd1, 5'h15, 5'h0A, 16'hA55A, 8'd0, 1'b1, 16'h0, 1'b0);
        run(1'b1, 2'd2, 5'h03, 5'h1F, 16'h0000, 8'd2, 1'b1, 16'hBEEF, 1'b0);
        run(1'b0, 2'd0, 5'h01, 5'h07, 16'h1234, 8'd1, 1'b1, 16'h0, 1'b0);
        run(1'b0, 2'd3, 5'h01, 5'h07, 16'h1234, 8'd1, 1'b1, 16'hC0DE, 1'b0);
        run(1'b0, 2'd2, 5'h01, 5'h07, 16'h1234, 8'd0, 1'b1, 16'h8001, 1'b0);
        run(1'b0, 2'd1, 5'h1F, 5'h1E, 16'hFFFF, 8'd5, 1'b1, 16'h0, 1'b0);
        run(1'b1, 2'd1, 5'h0C, 5'h05, 16'h7E81, 8'd3, 1'b1, 16'h0, 1'b1);

        // R9 and R10: no acknowledge, then stickiness
        run(1'b1, 2'd2, 5'h09, 5'h02, 16'h4321, 8'd1, 1'b0, 16'hFFFF, 1'b0);
        run(1'b0, 2'd1, 5'h02, 5'h03, 16'h5555, 8'd0, 1'b1, 16'h0, 1'b0);
        wr(2'd0, 32'h0000_00FF);
        rd(2'd0, v); check(v[28] == 1'b1, "R10 nonzero write keeps fail", v, 32'h1000_00FF);
        wr(2'd0, 32'h0); mdl_fail = 0;
        rd(2'd0, v); check(v == 0, "R10 zero write clears", v, 0);

        // random mix
        for (int n = 0; n < 24; n++) begin
            bit c22r = $urandom % 2;
            logic [1:0] opr = c22r ? (($urandom % 2) ? 2'd2 : 2'd1) : 2'($urandom % 4);
            run(c22r, opr, 5'($urandom), 5'($urandom), 16'($urandom), 8'($urandom % 4),
                ($urandom % 6) != 0, 16'($urandom), 1'b0);
            if ($urandom % 4 == 0) begin
                wr(2'd0, 32'h0); mdl_fail = 0;
                rd(2'd0, v); check(v == 0, "R10 random clear", v, 0);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule